// File: doc/BRIEF.md
# SPI Serial EEPROM Command Slave

This block is the slave side of a serial EEPROM that holds 8192 bytes. A master selects it by pulling `cs_n` low and sends bits on `si`. The block samples `si` when `sck` rises and changes `so` when `sck` falls, which is SPI mode 0. All pins are oversampled by the system clock `clk`. The first byte of each frame selects an operation:

- Read returns array bytes, beginning at a 16-bit address.
- Write stores one byte.
- The status register returns the state of the write-enable latch and the protection level.
- Write enable arms the latch.

No array change happens inside a frame. A write is held until `cs_n` rises. At that edge it is committed or dropped, depending on the write-enable latch and the protection level that `bp_level` selects. Any completed write frame disarms the latch.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset the write-enable latch is clear, `so_oe` is 0 (`so` high impedance) and `busy` is 0.
- R2: Opcode 8'h06 arms the write-enable latch only at the `cs_n` rising edge that ends its frame. Bytes that follow it in the same frame, including a full write sequence, leave the array unchanged.
- R3: A write frame is opcode 8'h02, then a 16-bit address MSB first, then one data byte MSB first (32 clocks). Address bits 15:13 are ignored. The byte is stored at the `cs_n` rising edge only if the latch is armed.
- R4: A write frame sent while the latch is clear leaves the array unchanged.
- R5: `bp_level` protects part of the 13-bit address space:
  - 0: nothing is protected.
  - 1: addresses with bits 12:11 = 2'b11 are protected.
  - 2: addresses with bit 12 = 1 are protected.
  - 3: every address is protected.
  A write to a protected address is dropped.
- R6: A write frame of at least 32 clocks clears the latch, whether its byte was stored or dropped. If `cs_n` rises before the data byte is complete, nothing is written and the latch is unchanged.
- R7: Opcode 8'h03 followed by a 16-bit address puts the addressed byte on `so`, MSB first, on clocks 24 to 31. Further clocks return the following addresses, wrapping from 8191 to 0.
- R8: Opcode 8'h05 puts the status byte {4'b0000, bp_level[1:0], latch, busy} on `so`, MSB first, on clocks 8 to 15. The byte repeats while clocking continues.
- R9: `so_oe` stays 0 while opcode and address bits are shifted in, for the whole of a frame with an unrecognised opcode, and while `cs_n` is high.
- R10: `busy` is high for exactly one `clk` cycle after each stored write and never goes high for a dropped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; a rising edge ends the frame |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in, sampled when `sck` rises |
| bp_level | input | 2 | Protection level applied to writes |
| so | output | 1 | Serial data out, high impedance when not driven |
| so_oe | output | 1 | High while `so` is driven |
| busy | output | 1 | One-cycle pulse when a write is stored |

## Verification
A wrong latch state shows up in two places. Status bit 1 is wrong in the next status frame. The array differs on the next read of the targeted address, because a write was either lost or stored when it should not have been. A wrong bit count or opcode decode shows up within the same frame: `so` is driven during the header, or every read byte is shifted by one bit. A wrong protection compare is only visible when a write lands exactly on a region boundary, so those addresses are written and read back at every level.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [7:0] OP_ARM    = 8'h06;
  localparam logic [7:0] OP_STORE  = 8'h02;
  localparam logic [7:0] OP_FETCH  = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;

  typedef enum logic [2:0] {
    MD_IDLE, MD_ARM, MD_STORE, MD_FETCH, MD_STATUS, MD_OTHER
  } eep_mode_t;

  function automatic eep_mode_t decode_op(input logic [7:0] op);
    case (op)
      OP_ARM:    return MD_ARM;
      OP_STORE:  return MD_STORE;
      OP_FETCH:  return MD_FETCH;
      OP_STATUS: return MD_STATUS;
      default:   return MD_OTHER;
    endcase
  endfunction

  // Region test: the top two bits of an aw-bit address decide the fraction.
  function automatic logic prot_hit(input logic [15:0] addr,
                                    input logic [1:0]  lvl,
                                    input int unsigned aw);
    logic [15:0] top;
    top = addr >> (aw - 2);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return top[1:0] == 2'b11;
      2'd2:    return top[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] make_status(input logic [1:0] lvl,
                                             input logic       latch,
                                             input logic       wip);
    return {4'b0000, lvl, latch, wip};
  endfunction

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_high,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  logic cs_q, cs_d, sck_q, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      cs_d  <= 1'b1;
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      si_s  <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      cs_d  <= cs_q;
      sck_q <= sck;
      sck_d <= sck_q;
      si_s  <= si;
    end
  end

  assign cs_high  = cs_q;
  assign cs_rise  = cs_q & ~cs_d;
  assign sck_rise = ~cs_q & sck_q & ~sck_d;
  assign sck_fall = ~cs_q & ~sck_q & sck_d;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eep_frame.sv
module eep_frame
  import eep_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_high,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          si_s,
  input  logic [1:0]    bp_level,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] raddr,
  output logic          commit,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wel,
  output logic          wip,
  output logic          so_bit,
  output logic          so_oe,
  output logic [5:0]    bit_cnt
);
  localparam logic [5:0] CNT_OP   = 6'd8;
  localparam logic [5:0] CNT_ADDR = 6'd24;
  localparam logic [5:0] CNT_DATA = 6'd32;
  localparam logic [5:0] CNT_TOP  = 6'd39;

  eep_mode_t     mode;
  logic [7:0]    shreg, out_sh;
  logic [AW-1:0] addr_sh, addr_r;
  logic          data_full, out_live;
  logic [5:0]    nxt;
  logic [7:0]    byte_in;
  logic [AW-1:0] addr_in;
  logic          wr_done;
  logic [7:0]    status;

  assign nxt     = (bit_cnt == CNT_TOP) ? CNT_DATA : bit_cnt + 6'd1;
  assign byte_in = {shreg[6:0], si_s};
  assign addr_in = {addr_sh[AW-2:0], si_s};
  assign raddr   = (nxt == CNT_ADDR) ? addr_in : addr_r + 1'b1;
  assign status  = make_status(bp_level, wel, wip);
  assign wr_done = cs_rise && (mode == MD_STORE) && data_full;
  assign commit  = wr_done && wel && !prot_hit(16'(addr_r), bp_level, AW);
  assign wr_addr = addr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MD_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      out_sh    <= '0;
      addr_sh   <= '0;
      addr_r    <= '0;
      wr_data   <= '0;
      data_full <= 1'b0;
      out_live  <= 1'b0;
      so_bit    <= 1'b0;
      so_oe     <= 1'b0;
      wel       <= 1'b0;
      wip       <= 1'b0;
    end else begin
      wip <= commit;
      if (cs_rise) begin
        if (mode == MD_ARM) wel <= 1'b1;
        else if (wr_done)   wel <= 1'b0;
      end
      if (cs_high) begin
        bit_cnt   <= '0;
        mode      <= MD_IDLE;
        data_full <= 1'b0;
        out_live  <= 1'b0;
        so_oe     <= 1'b0;
      end else if (sck_rise) begin
        bit_cnt <= nxt;
        shreg   <= byte_in;
        if (nxt == CNT_OP) begin
          mode <= decode_op(byte_in);
          if (decode_op(byte_in) == MD_STATUS) begin
            out_sh   <= status;
            out_live <= 1'b1;
          end
        end
        if ((mode == MD_FETCH || mode == MD_STORE) && bit_cnt >= CNT_OP && bit_cnt < CNT_ADDR)
          addr_sh <= addr_in;
        if (mode == MD_FETCH && (nxt == CNT_ADDR || nxt == CNT_DATA)) begin
          out_sh   <= rdata;
          addr_r   <= raddr;
          out_live <= 1'b1;
        end
        if (mode == MD_STATUS && nxt[2:0] == 3'd0)
          out_sh <= status;
        if (mode == MD_STORE && nxt == CNT_DATA && !data_full) begin
          wr_data   <= byte_in;
          data_full <= 1'b1;
          addr_r    <= addr_sh;
        end
      end else if (sck_fall && out_live) begin
        so_bit <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
        so_oe  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave #(
  parameter int ADDR_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic [1:0] bp_level,
  output logic       so,
  output logic       so_oe,
  output logic       busy
);
  logic              cs_high, cs_rise, sck_rise, sck_fall, si_s;
  logic              commit, wel, so_bit;
  logic [5:0]        bit_cnt;
  logic [ADDR_W-1:0] wr_addr, raddr;
  logic [7:0]        wr_data, rdata;

  eep_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_high(cs_high), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s)
  );

  eep_frame #(.AW(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_high(cs_high), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
    .bp_level(bp_level), .rdata(rdata), .raddr(raddr), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data), .wel(wel), .wip(busy),
    .so_bit(so_bit), .so_oe(so_oe), .bit_cnt(bit_cnt)
  );

  eep_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(commit), .waddr(wr_addr), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata)
  );

  assign so = so_oe ? so_bit : 1'bz;
endmodule

// File: rtl/eep_spi_checker.sv
module eep_spi_checker
  import eep_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_high,
  input logic              cs_rise,
  input logic              commit,
  input logic              wel,
  input logic              busy,
  input logic              so_oe,
  input logic [5:0]        bit_cnt,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        bp_level
);
  a_r2_latch_arms_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  a_r3_store_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cs_rise && wel));

  a_r5_no_protected_store: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !prot_hit(16'(wr_addr), bp_level, ADDR_W));

  a_r6_latch_drops_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !wel);

  a_r9_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !so_oe);

  a_r9_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (bit_cnt >= 6'd8));

  a_r10_busy_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  a_r10_busy_only_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(commit));
endmodule

bind eeprom_spi_slave eep_spi_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_high(cs_high), .cs_rise(cs_rise),
  .commit(commit), .wel(wel), .busy(busy), .so_oe(so_oe),
  .bit_cnt(bit_cnt), .wr_addr(wr_addr), .bp_level(bp_level)
);

// File: tb/eeprom_spi_slave_bench.sv
`timescale 1ns/1ps
module eeprom_spi_slave_bench;
  localparam int HALF = 4;
  localparam int SIZE = 8192;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, so, so_oe, busy;
  logic [1:0] bp;

  eeprom_spi_slave u_eeprom_spi_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .bp_level(bp), .so(so), .so_oe(so_oe), .busy(busy)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, busy_cnt = 0, exp_busy = 0;
  logic [7:0] shadow [SIZE];
  bit         known  [SIZE];
  bit         wel_m;
  logic [7:0] txb [0:7];
  logic [7:0] rxb [0:7];
  logic       oe_seen [0:7];
  logic       oe_all  [0:7];

  always @(posedge clk) if (busy === 1'b1) busy_cnt++;

  function automatic bit exp_prot(int a, int lvl);
    case (lvl)
      0: return 1'b0;
      1: return a >= 6144;
      2: return a >= 4096;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return (8'(bp) << 2) | (wel_m ? 8'h02 : 8'h00);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input int nbits);
    logic r, oe;
    for (int k = 0; k < 8; k++) begin oe_seen[k] = 1'b0; oe_all[k] = 1'b1; end
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      si = txb[i/8][7 - i%8];
      tick(HALF);
      r = so; oe = so_oe;
      rxb[i/8][7 - i%8] = r;
      oe_seen[i/8] = oe_seen[i/8] | oe;
      oe_all[i/8]  = oe_all[i/8] & oe;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic do_arm();
    txb[0] = 8'h06;
    run_frame(8);
    wel_m = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    int a13;
    a13 = int'(a[12:0]);
    txb[0] = 8'h02; txb[1] = a[15:8]; txb[2] = a[7:0]; txb[3] = d;
    run_frame(32);
    if (wel_m && !exp_prot(a13, int'(bp))) begin
      shadow[a13] = d; known[a13] = 1'b1; exp_busy++;
    end
    wel_m = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string tag);
    int ad;
    txb[0] = 8'h03; txb[1] = a[15:8]; txb[2] = a[7:0];
    for (int k = 3; k < 8; k++) txb[k] = 8'h00;
    run_frame(24 + 8*n);
    chk(!oe_seen[0] && !oe_seen[1] && !oe_seen[2], {"R9 header quiet (", tag, ")"},
        {31'd0, oe_seen[2]}, 32'd0);
    for (int k = 0; k < n; k++) begin
      ad = (int'(a[12:0]) + k) % SIZE;
      chk(oe_all[3+k], {"R7 so driven (", tag, ")"}, {31'd0, oe_all[3+k]}, 32'd1);
      if (known[ad])
        chk(rxb[3+k] === shadow[ad], {"R7 read data (", tag, ")"}, {24'd0, rxb[3+k]}, {24'd0, shadow[ad]});
    end
  endtask

  task automatic do_status(input int n, input string tag);
    txb[0] = 8'h05;
    for (int k = 1; k < 8; k++) txb[k] = 8'h00;
    run_frame(8 + 8*n);
    for (int k = 1; k <= n; k++)
      chk(oe_all[k] && rxb[k] === exp_status(), {"R8 status (", tag, ")"},
          {24'd0, rxb[k]}, {24'd0, exp_status()});
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] edges [6];
    void'($urandom(32'd9177));
    for (int i = 0; i < SIZE; i++) known[i] = 1'b0;
    wel_m = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; bp = 2'd0;
    tick(5);
    chk(so_oe === 1'b0 && so === 1'bz, "R1 reset output quiet", {31'd0, so_oe}, 32'd0);
    chk(busy === 1'b0, "R1 reset busy low", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    tick(4);
    do_status(1, "R1 latch clear after reset");

    do_arm();
    do_write(16'h0010, 8'h3C);
    do_read(16'h0010, 1, "R3 basic store");
    do_write(16'h0010, 8'hFF);
    do_read(16'h0010, 1, "R4 store without latch");

    txb[0] = 8'h06; txb[1] = 8'h02; txb[2] = 8'h00; txb[3] = 8'h10; txb[4] = 8'h55;
    run_frame(40);
    wel_m = 1'b1;
    do_read(16'h0010, 1, "R2 same frame store ignored");
    do_status(1, "R2 latch armed at deselect");
    do_write(16'h0010, 8'h77);
    do_status(1, "R6 latch cleared by store");
    do_read(16'h0010, 1, "R3 committed after arm");

    do_arm();
    do_write(16'hE020, 8'h9A);
    do_read(16'h0020, 1, "R3 upper address bits ignored");

    do_arm();
    do_write(16'h0030, 8'h11);
    do_arm();
    txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h30; txb[3] = 8'hEE;
    run_frame(28);
    do_read(16'h0030, 1, "R6 aborted frame no store");
    do_status(1, "R6 latch kept after abort");
    do_write(16'h0030, 8'h12);

    edges[0] = 16'h17FF; edges[1] = 16'h1800; edges[2] = 16'h0FFF;
    edges[3] = 16'h1000; edges[4] = 16'h0000; edges[5] = 16'h1FFF;
    for (int lvl = 0; lvl < 4; lvl++) begin
      bp = 2'(lvl);
      for (int e = 0; e < 6; e++) begin
        do_arm();
        do_write(edges[e], 8'(8'h40 + 8'(lvl*16) + 8'(e)));
        do_read(edges[e], 1, "R5 protection boundary");
      end
    end
    chk(busy_cnt == exp_busy, "R10 busy pulses per stored write", 32'(busy_cnt), 32'(exp_busy));

    bp = 2'd0;
    do_arm(); do_write(16'h0001, 8'hA1);
    do_arm(); do_write(16'h1FFF, 8'hB2);
    do_arm(); do_write(16'h0000, 8'hC3);
    do_read(16'hFFFF, 3, "R7 sequential wrap");

    bp = 2'd2;
    do_arm();
    do_status(3, "R8 repeated status");

    txb[0] = 8'hA7; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    run_frame(32);
    chk(!oe_seen[0] && !oe_seen[1] && !oe_seen[2] && !oe_seen[3], "R9 unknown opcode quiet",
        {28'd0, oe_seen[3], oe_seen[2], oe_seen[1], oe_seen[0]}, 32'd0);

    for (int it = 0; it < 70; it++) begin
      int op;
      logic [15:0] a;
      op = int'($urandom % 5);
      a  = 16'($urandom) & 16'hE00F;
      if ($urandom % 2 == 0) a = a | 16'h1FF0;
      if (it % 10 == 0) bp = 2'($urandom % 4);
      case (op)
        0: do_arm();
        1: begin do_arm(); do_write(a, 8'($urandom)); end
        2: do_write(a, 8'($urandom));
        3: do_read(a, 1 + int'($urandom % 2), "R7 random read");
        default: do_status(1, "R8 random status");
      endcase
    end
    chk(busy_cnt == exp_busy, "R10 busy count after random traffic", 32'(busy_cnt), 32'(exp_busy));
    finish_run();
  end
endmodule